// File: doc/BRIEF.md
# Enable-Gated AND-NOT Latch Bank

This block is a cycle-level model of a tiny short-term memory. It holds a few active-high set/clear storage cells plus one more cell of the same construction that serves as a master on/off switch. Every cell is made only from one primitive: a gate whose output is its excitatory input with its inhibitory input masked off (X AND NOT Y). Each primitive is a single register, so every gate adds exactly one clock tick. As a result, the order in which a cell's outputs change can be seen directly at the ports.

A cell has four gates. Two inverters take their excitatory input from the cell's enable and invert the set and clear lines. Two cross-coupled gates then form the stored bit and its complement: the complement is the inverted set masked by the bit, and the bit is the inverted clear masked by the complement. The switch cell's enable is tied high. Its true output drives the enable of every storage cell. Turning the switch off forces both outputs of every storage cell low, which loses their contents. Turning it back on without a set or clear pulse leaves the storage cells toggling until one arrives.

Top module: `andnot_latch_bank`

## Requirements
- R1: Every gate is registered and adds one tick. A set or clear pulse first sampled at clock edge t leaves the cell outputs unchanged after edge t, because the pulse is still passing through the inverter.
- R2: While reset is asserted, and directly after it is released, every cell shows bit 0 and complement 1. Because the switch starts off, two edges after reset release every storage cell shows bit 0 and complement 0, while the switch keeps 0/1.
- R3: In an enabled cell holding 0, a set held high for three sampled edges starting at edge t works as follows. The complement falls after edge t+1 while the bit is still 0. The bit rises after edge t+2. The cell then stays at bit 1, complement 0 after release.
- R4: In an enabled cell holding 1, a clear held for three edges from edge t works as follows. The bit falls after edge t+1 while the complement is still 0. The complement rises after edge t+2. The cell then stays at bit 0, complement 1.
- R5: A set applied to a cell already holding 1, or a clear applied to a cell already holding 0, changes neither output on any tick.
- R6: Once the switch bit has been low at two consecutive edges, every storage cell shows bit 0 and complement 0. Set and clear pulses applied to storage cells in that state leave them at 0/0.
- R7: If the switch bit rises after edge u and no storage pulse arrives, every storage cell shows 1/1 after edge u+2 and 0/0 after edge u+3. It keeps alternating between these two states on each tick.
- R8: A set or clear held for three ticks on a toggling storage cell settles it at 1/0 or 0/1 respectively, and it stays there.
- R9: A pulse on one storage cell leaves the outputs of every other stable storage cell unchanged.
- R10: The switch cell follows the same set and clear timing as R3 and R4. Its bit rises two edges after its set is first sampled, and falls one edge after its clear is first sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every gate updates on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| setIn | input | NUM_STORE | Per-storage-cell set pulse, active high |
| clrIn | input | NUM_STORE | Per-storage-cell clear pulse, active high |
| swSet | input | 1 | Set pulse for the switch cell (turns storage on) |
| swClr | input | 1 | Clear pulse for the switch cell (turns storage off) |
| bitOut | output | NUM_STORE | True output of each storage cell |
| bitNOut | output | NUM_STORE | Complement output of each storage cell |
| swBit | output | 1 | True output of the switch cell |
| swBitN | output | 1 | Complement output of the switch cell |

## Verification
The bench builds the bank with its default of three storage cells. With that size it can sweep every cell through both a set and a clear, from both a stored 0 and a stored 1, and count the tick on which each output moves. Three cells are enough to show that neighbours are left untouched by a pulse. The switch cell's timing is checked in both directions. Both toggling phases are entered by cycling the switch twice, and pulses issued while storage is off are shown to be ignored.

// File: rtl/andnot_latch_pkg.sv
package andnot_latch_pkg;

  // Strobes from the enable-fed inverter stage to the cross-coupled pair.
  typedef struct packed {
    logic invSet;
    logic invRst;
  } cellStrobe_t;

endpackage

// File: rtl/andnot_gate.sv
module andnot_gate #(
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic excit,
  input  logic inhib,
  output logic q
);

  // One registered AND-NOT primitive: one tick of delay.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) q <= RESET_VAL;
    else       q <= excit & ~inhib;
  end

endmodule

// File: rtl/latch_ctrl.sv
module latch_ctrl #(
  parameter int NUM_CELLS = 4
) (
  input  logic                                        clk,
  input  logic                                        rstN,
  input  logic [NUM_CELLS-1:0]                        enIn,
  input  logic [NUM_CELLS-1:0]                        setIn,
  input  logic [NUM_CELLS-1:0]                        clrIn,
  output andnot_latch_pkg::cellStrobe_t [NUM_CELLS-1:0] strobe
);

  // Enable-fed inverters: excitatory input is the enable, inhibitory the pulse.
  for (genvar i = 0; i < NUM_CELLS; i++) begin : g_inv
    andnot_gate #(.RESET_VAL(1'b1)) setInv_i (
      .clk(clk), .rstN(rstN), .excit(enIn[i]), .inhib(setIn[i]),
      .q(strobe[i].invSet)
    );
    andnot_gate #(.RESET_VAL(1'b1)) rstInv_i (
      .clk(clk), .rstN(rstN), .excit(enIn[i]), .inhib(clrIn[i]),
      .q(strobe[i].invRst)
    );
  end

endmodule

// File: rtl/latch_core.sv
module latch_core #(
  parameter int NUM_CELLS = 4
) (
  input  logic                                        clk,
  input  logic                                        rstN,
  input  andnot_latch_pkg::cellStrobe_t [NUM_CELLS-1:0] strobe,
  output logic [NUM_CELLS-1:0]                        bitQ,
  output logic [NUM_CELLS-1:0]                        compQ
);

  for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
    // Complement = inverted set AND NOT bit.
    andnot_gate #(.RESET_VAL(1'b1)) compGate_i (
      .clk(clk), .rstN(rstN), .excit(strobe[i].invSet), .inhib(bitQ[i]),
      .q(compQ[i])
    );
    // Bit = inverted clear AND NOT complement.
    andnot_gate #(.RESET_VAL(1'b0)) bitGate_i (
      .clk(clk), .rstN(rstN), .excit(strobe[i].invRst), .inhib(compQ[i]),
      .q(bitQ[i])
    );

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
      (strobe[i].invSet && strobe[i].invRst && (bitQ[i] != compQ[i]))
      |=> ($stable(bitQ[i]) && $stable(compQ[i])));  // R5
    AST_SET_FALL_FIRST: assert property (@(posedge clk) disable iff (!rstN)
      $fell(compQ[i]) |-> !bitQ[i]);  // R3
    AST_CLR_FALL_FIRST: assert property (@(posedge clk) disable iff (!rstN)
      $fell(bitQ[i]) |-> !compQ[i]);  // R4
    AST_BOTH_HIGH_COLLAPSES: assert property (@(posedge clk) disable iff (!rstN)
      (bitQ[i] && compQ[i]) |=> (!bitQ[i] && !compQ[i]));  // R7
  end

endmodule

// File: rtl/andnot_latch_bank.sv
module andnot_latch_bank #(
  parameter int NUM_STORE = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_STORE-1:0] setIn,
  input  logic [NUM_STORE-1:0] clrIn,
  input  logic                 swSet,
  input  logic                 swClr,
  output logic [NUM_STORE-1:0] bitOut,
  output logic [NUM_STORE-1:0] bitNOut,
  output logic                 swBit,
  output logic                 swBitN
);

  localparam int NUM_CELLS = NUM_STORE + 1;
  localparam int SW_IDX    = NUM_STORE;

  logic [NUM_CELLS-1:0] enVec, setVec, clrVec, bitQ, compQ;
  andnot_latch_pkg::cellStrobe_t [NUM_CELLS-1:0] strobe;

  // Switch cell runs from a constant-high enable; storage from the switch bit.
  assign enVec  = {1'b1, {NUM_STORE{bitQ[SW_IDX]}}};
  assign setVec = {swSet, setIn};
  assign clrVec = {swClr, clrIn};

  latch_ctrl #(.NUM_CELLS(NUM_CELLS)) ctrl_i (
    .clk(clk), .rstN(rstN), .enIn(enVec), .setIn(setVec), .clrIn(clrVec),
    .strobe(strobe)
  );

  latch_core #(.NUM_CELLS(NUM_CELLS)) core_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .bitQ(bitQ), .compQ(compQ)
  );

  assign bitOut  = bitQ[NUM_STORE-1:0];
  assign bitNOut = compQ[NUM_STORE-1:0];
  assign swBit   = bitQ[SW_IDX];
  assign swBitN  = compQ[SW_IDX];

  // Consecutive edges at which the switch bit was seen low (saturating).
  logic [1:0] offTicks;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 offTicks <= 2'd0;
    else if (bitQ[SW_IDX])     offTicks <= 2'd0;
    else if (offTicks != 2'd3) offTicks <= offTicks + 2'd1;
  end

  AST_OFF_CLEARS_STORAGE: assert property (@(posedge clk) disable iff (!rstN)
    (offTicks >= 2'd2) |-> (bitOut == '0 && bitNOut == '0));  // R6

endmodule

// File: tb/andnot_latch_bank_tb_top.sv
`timescale 1ns/1ps
module andnot_latch_bank_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] setIn = '0, clrIn = '0;
  logic       swSet = 1'b0, swClr = 1'b0;
  logic [2:0] bitOut, bitNOut;
  logic       swBit, swBitN;
  int         tests = 0, fails = 0;
  bit         finished = 1'b0;

  always #2.5 clk = ~clk;

  andnot_latch_bank #(.NUM_STORE(3)) dut_i (
    .clk(clk), .rstN(rstN), .setIn(setIn), .clrIn(clrIn),
    .swSet(swSet), .swClr(swClr), .bitOut(bitOut), .bitNOut(bitNOut),
    .swBit(swBit), .swBitN(swBitN)
  );

  task automatic chk(string req, string what, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic logic qOf(int idx);
    return (idx == 3) ? swBit : bitOut[idx];
  endfunction
  function automatic logic qnOf(int idx);
    return (idx == 3) ? swBitN : bitNOut[idx];
  endfunction

  task automatic drive(int idx, bit isSet, logic v);
    if (idx == 3) begin
      if (isSet) swSet = v; else swClr = v;
    end else begin
      if (isSet) setIn[idx] = v; else clrIn[idx] = v;
    end
  endtask

  task automatic chkAllStore(string req, string what, logic b, logic n);
    for (int j = 0; j < 3; j++) begin
      chk(req, $sformatf("%s cell%0d bit", what, j), bitOut[j], b);
      chk(req, $sformatf("%s cell%0d comp", what, j), bitNOut[j], n);
    end
  endtask

  // Three-tick pulse with per-tick timing checks on a stable storage cell.
  task automatic pulseChecked(int idx, bit isSet);
    logic b0 = qOf(idx), n0 = qnOf(idx);
    logic [2:0] ob = bitOut, on = bitNOut;
    bit already = (b0 == logic'(isSet));
    string rq = isSet ? "R3" : "R4";
    drive(idx, isSet, 1'b1);
    step();  // after edge t
    chk("R1", "no change after edge t bit", qOf(idx), b0);
    chk("R1", "no change after edge t comp", qnOf(idx), n0);
    step();  // after edge t+1
    if (already) begin
      chk("R5", "redundant pulse bit", qOf(idx), b0);
      chk("R5", "redundant pulse comp", qnOf(idx), n0);
    end else begin
      chk(rq, "t+1 bit", qOf(idx), 1'b0);
      chk(rq, "t+1 comp", qnOf(idx), 1'b0);
    end
    step();  // after edge t+2
    chk(already ? "R5" : rq, "t+2 bit", qOf(idx), logic'(isSet));
    chk(already ? "R5" : rq, "t+2 comp", qnOf(idx), logic'(!isSet));
    drive(idx, isSet, 1'b0);
    step(); step();
    chk(rq, "held bit", qOf(idx), logic'(isSet));
    chk(rq, "held comp", qnOf(idx), logic'(!isSet));
    for (int j = 0; j < 3; j++) if (j != idx) begin
      chk("R9", $sformatf("neighbour%0d bit", j), bitOut[j], ob[j]);
      chk("R9", $sformatf("neighbour%0d comp", j), bitNOut[j], on[j]);
    end
  endtask

  // Three-tick pulse with no intermediate checks.
  task automatic pulseRaw(int idx, bit isSet);
    drive(idx, isSet, 1'b1);
    step(); step(); step();
    drive(idx, isSet, 1'b0);
  endtask

  // Switch on, then check the storage toggling pattern (R10, R7).
  task automatic switchOn();
    swSet = 1'b1;
    step();
    chk("R1", "switch bit after t", swBit, 1'b0);
    step();
    chk("R10", "switch comp falls t+1", swBitN, 1'b0);
    chk("R10", "switch bit still low t+1", swBit, 1'b0);
    step();
    chk("R10", "switch bit rises t+2", swBit, 1'b1);
    swSet = 1'b0;
    step();
    chkAllStore("R7", "t+3", 1'b0, 1'b0);
    step();
    chkAllStore("R7", "t+4 high", 1'b1, 1'b1);
    step();
    chkAllStore("R7", "t+5 low", 1'b0, 1'b0);
    step();
    chkAllStore("R7", "t+6 high", 1'b1, 1'b1);
  endtask

  initial begin
    #(5.0 * 50000);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    chk("R2", "in reset switch bit", swBit, 1'b0);
    chk("R2", "in reset switch comp", swBitN, 1'b1);
    chkAllStore("R2", "in reset", 1'b0, 1'b1);
    rstN = 1'b1;
    step();
    chkAllStore("R2", "one edge after reset", 1'b0, 1'b1);
    step();
    chkAllStore("R2", "two edges after reset", 1'b0, 1'b0);
    chk("R2", "switch bit after reset", swBit, 1'b0);
    chk("R2", "switch comp after reset", swBitN, 1'b1);
    step();
    setIn = 3'b111;
    step(); step(); step();
    setIn = 3'b000;
    step();
    chkAllStore("R6", "set while off", 1'b0, 1'b0);

    switchOn();

    // Settle each cell out of the toggling state.
    pulseRaw(0, 1'b1); step(); step();
    chk("R8", "cell0 set bit", bitOut[0], 1'b1);
    chk("R8", "cell0 set comp", bitNOut[0], 1'b0);
    pulseRaw(1, 1'b0); step(); step();
    chk("R8", "cell1 clear bit", bitOut[1], 1'b0);
    chk("R8", "cell1 clear comp", bitNOut[1], 1'b1);
    pulseRaw(2, 1'b1); step(); step();
    chk("R8", "cell2 set bit", bitOut[2], 1'b1);
    chk("R8", "cell2 set comp", bitNOut[2], 1'b0);
    step(); step(); step();
    chk("R8", "cell0 stays", bitOut[0], 1'b1);
    chk("R8", "cell1 stays", bitNOut[1], 1'b1);

    // Sweep: every cell, both operations, from both starting values.
    for (int rep = 0; rep < 2; rep++)
      for (int c = 0; c < 3; c++)
        for (int op = 0; op < 2; op++)
          pulseChecked(c, op == 0);

    // Switch off.
    swClr = 1'b1;
    step();
    chk("R1", "switch unchanged t", swBit, 1'b1);
    step();
    chk("R10", "switch bit falls t+1", swBit, 1'b0);
    chk("R10", "switch comp still low t+1", swBitN, 1'b0);
    step();
    chk("R10", "switch comp rises t+2", swBitN, 1'b1);
    swClr = 1'b0;
    step();
    chkAllStore("R6", "storage cleared", 1'b0, 1'b0);
    setIn = 3'b111;
    for (int k = 0; k < 3; k++) begin
      step();
      chkAllStore("R6", "set ignored while off", 1'b0, 1'b0);
    end
    setIn = 3'b000;
    clrIn = 3'b111;
    for (int k = 0; k < 3; k++) begin
      step();
      chkAllStore("R6", "clear ignored while off", 1'b0, 1'b0);
    end
    clrIn = 3'b000;
    step(); step();
    chkAllStore("R6", "still off", 1'b0, 1'b0);

    switchOn();
    pulseRaw(0, 1'b0); step(); step();
    chk("R8", "cell0 clear from toggle bit", bitOut[0], 1'b0);
    chk("R8", "cell0 clear from toggle comp", bitNOut[0], 1'b1);
    pulseRaw(1, 1'b1); step(); step();
    chk("R8", "cell1 set from toggle bit", bitOut[1], 1'b1);
    chk("R8", "cell1 set from toggle comp", bitNOut[1], 1'b0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule